// File: doc/BRIEF.md
# Shared On-the-Fly Twiddle Generator

This block supplies the rotation factors for a radix-2 pipelined FFT whose input arrives on several parallel time-decimated lanes. It keeps no coefficient table. The factors are computed at run time. An exponent sequencer steps through the exponents a stage needs. The exponent is folded into the first eighth of the circle, and an unrolled CORDIC rotator yields cosine and sine. The result is then mapped back to the full circle by swapping and negating the two parts.

One computed factor is copied onto a separate output slice for every dual-input butterfly group. All groups therefore see the same value on the same cycle, and no group holds a private copy. The twiddle width is a parameter of its own and is not tied to the width of the data path. The FFT controller pulses `start` with the stage number, then raises `adv` once for every butterfly that needs a factor.

Top module: `twiddle_gen`

## Requirements
- R1: For a request with exponent k, the output is W^k = exp(-j2πk/N) scaled by MAX = 2^(TW_W-1)-1 (262143 by default), with N = 2^LOGN (65536 by default). The real part is within 2 LSB of round(MAX·cos(2πk/N)), and the imaginary part is within 2 LSB of round(-MAX·sin(2πk/N)). Both parts are TW_W-bit two's complement, and neither ever takes the value -2^(TW_W-1).
- R2: Exponent 0 yields exactly real = +MAX and imaginary = 0.
- R3: Exponent N/4 yields exactly real = 0 and imaginary = -MAX.
- R4: A cycle with `start` high loads `stage`. If `adv` is high in that same cycle, that request carries exponent 0. Otherwise the next request carries exponent 0.
- R5: Each `adv` request uses the current exponent, after which the exponent grows by N >> (stage+1). Any stage value of LOGN-1 or more gives a step of 1.
- R6: Each request produces exactly one `tw_vld` pulse. It comes on the clock edge that lies CORDIC_ITERS+1 edges after the edge that sampled the request (22 by default). A new request is accepted on every cycle, and outputs keep request order.
- R7: All NLANES/2 group slices of `tw_re` and `tw_im` carry identical values on every valid cycle. Group g occupies bits [g·TW_W +: TW_W].
- R8: A cycle with `adv` low produces no output and leaves the exponent unchanged, so the requests after a gap continue the sequence.
- R9: After reset, `tw_vld` is low, the exponent is 0 and the stage is 0, which gives a step of N/2.
- R10: The exponent wraps modulo N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the stage and restarts the exponent at 0 |
| stage | input | SW ($clog2(LOGN)+1) | FFT stage number, sampled on `start` |
| adv | input | 1 | Request one twiddle for the next butterfly |
| tw_vld | output | 1 | Twiddle outputs are valid |
| tw_exp | output | LOGN | Exponent k of the twiddle on the outputs |
| tw_re | output | NLANES/2·TW_W | Real part, repeated once per butterfly group |
| tw_im | output | NLANES/2·TW_W | Imaginary part, repeated once per butterfly group |

## Verification
The bench sweeps the whole circle with a fine step, so every octant is exercised, including odd octants whose folded angle reaches exactly π/4. A wrong swap or sign in the octant map would show up as an error of the full magnitude there. Exponents 0 and N/4 are checked for exact values, because a CORDIC without the zero-angle bypass returns a value a few LSB off full scale. Requests with `start` and `adv` in the same cycle, gapped requests, a restart in mid-stream and out-of-range stage numbers probe the sequencer. An off-by-one in the restart would shift every following exponent, and a leak through a gap would show up as an extra pulse or a broken latency count. A steep stage is driven until it wraps, so an overflowing exponent would break the sequence.

// File: rtl/twg_pkg.sv
package twg_pkg;

   localparam real TWG_PI = 3.14159265358979323846;

   // octant number and zero-angle flag carried beside the datapath
   typedef struct packed {
      logic [2:0] oct;
      logic       zero;
   } twg_side_t;

   // product of 1/sqrt(1+2^-2i): the CORDIC magnitude compensation
   function automatic real cordic_gain(input int iters);
      real g;
      g = 1.0;
      for (int i = 0; i < iters; i++) begin
         g = g / $sqrt(1.0 + 1.0 / (4.0 ** i));
      end
      return g;
   endfunction

   // elementary rotation angle of iteration i, in turns
   function automatic real atan_turns(input int i);
      return $atan(1.0 / (2.0 ** i)) / (2.0 * TWG_PI);
   endfunction

endpackage

// File: rtl/twg_seq.sv
module twg_seq #(
   parameter int LOGN = 16,
   parameter int SW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            adv,
   input  logic [SW-1:0]   stage,
   output logic            req_vld,
   output logic [LOGN-1:0] req_exp
);

   logic [SW-1:0]   stage_q;
   logic [LOGN-1:0] exp_q;
   logic [LOGN-1:0] step_q;
   logic [LOGN-1:0] step_new;

   function automatic logic [LOGN-1:0] step_of(input logic [SW-1:0] s);
      if (int'(s) >= LOGN - 1) return LOGN'(1);
      return LOGN'(1) << (LOGN - 1 - int'(s));
   endfunction

   always_comb begin
      step_q   = step_of(stage_q);
      step_new = step_of(stage);
      req_vld  = adv;
      req_exp  = start ? '0 : exp_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         exp_q   <= '0;
      end else if (start) begin
         stage_q <= stage;
         exp_q   <= adv ? step_new : '0;
      end else if (adv) begin
         exp_q   <= exp_q + step_q;
      end
   end

endmodule

// File: rtl/twg_fold.sv
module twg_fold
   import twg_pkg::*;
#(
   parameter int LOGN = 16,
   parameter int PW   = 25
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic [LOGN-1:0]       in_exp,
   output logic                  out_vld,
   output logic [LOGN-1:0]       out_exp,
   output twg_side_t             out_side,
   output logic signed [PW-1:0]  out_z
);

   localparam int RW = LOGN - 3;
   localparam int SH = PW - LOGN;

   logic [2:0]           oct;
   logic [RW-1:0]        rem;
   logic [RW:0]          rem_f;
   logic signed [PW-1:0] z_c;

   always_comb begin
      oct   = in_exp[LOGN-1 -: 3];
      rem   = in_exp[RW-1:0];
      // odd octants measure the angle back from the octant's far edge
      rem_f = oct[0] ? (((RW+1)'(1) << RW) - {1'b0, rem}) : {1'b0, rem};
      z_c   = $signed(PW'(rem_f) << SH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   always_ff @(posedge clk) begin
      out_exp       <= in_exp;
      out_side.oct  <= oct;
      out_side.zero <= (rem_f == '0);
      out_z         <= z_c;
   end

endmodule

// File: rtl/twg_cordic.sv
module twg_cordic
   import twg_pkg::*;
#(
   parameter int LOGN  = 16,
   parameter int TW_W  = 19,
   parameter int GB    = 6,
   parameter int PW    = 25,
   parameter int ITERS = 21
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_vld,
   input  logic [LOGN-1:0]               in_exp,
   input  twg_side_t                     in_side,
   input  logic signed [PW-1:0]          in_z,
   output logic                          out_vld,
   output logic [LOGN-1:0]               out_exp,
   output twg_side_t                     out_side,
   output logic signed [TW_W+GB:0]       out_x,
   output logic signed [TW_W+GB:0]       out_y
);

   localparam int  XW   = TW_W + GB + 1;
   localparam int  MAXV = (1 << (TW_W - 1)) - 1;
   localparam real KG   = cordic_gain(ITERS);
   localparam logic signed [XW-1:0] X0 =
      XW'($rtoi(real'(MAXV) * KG * (2.0 ** GB) + 0.5));

   for (genvar g = 0; g < ITERS; g++) begin : g_it
      localparam logic signed [PW-1:0] ANG =
         PW'($rtoi(atan_turns(g) * (2.0 ** PW) + 0.5));

      logic                 vi, vq;
      logic [LOGN-1:0]      ei, eq;
      twg_side_t            si, sq;
      logic signed [XW-1:0] xi, yi, xq, yq;
      logic signed [PW-1:0] zi;
      logic                 dir;

      if (g == 0) begin : g_src
         assign vi = in_vld;
         assign ei = in_exp;
         assign si = in_side;
         assign xi = X0;
         assign yi = '0;
         assign zi = in_z;
      end else begin : g_src
         assign vi = g_it[g-1].vq;
         assign ei = g_it[g-1].eq;
         assign si = g_it[g-1].sq;
         assign xi = g_it[g-1].xq;
         assign yi = g_it[g-1].yq;
         assign zi = g_it[g-1].g_z.zq;
      end

      assign dir = ~zi[PW-1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vq <= 1'b0;
         else        vq <= vi;
      end

      always_ff @(posedge clk) begin
         eq <= ei;
         sq <= si;
         if (dir) begin
            xq <= xi - (yi >>> g);
            yq <= yi + (xi >>> g);
         end else begin
            xq <= xi + (yi >>> g);
            yq <= yi - (xi >>> g);
         end
      end

      // the residual angle is only needed by a following iteration
      if (g < ITERS - 1) begin : g_z
         logic signed [PW-1:0] zq;
         always_ff @(posedge clk) begin
            zq <= dir ? (zi - ANG) : (zi + ANG);
         end
      end
   end

   assign out_vld  = g_it[ITERS-1].vq;
   assign out_exp  = g_it[ITERS-1].eq;
   assign out_side = g_it[ITERS-1].sq;
   assign out_x    = g_it[ITERS-1].xq;
   assign out_y    = g_it[ITERS-1].yq;

endmodule

// File: rtl/twg_unfold.sv
module twg_unfold
   import twg_pkg::*;
#(
   parameter int LOGN = 16,
   parameter int TW_W = 19,
   parameter int GB   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic [LOGN-1:0]          in_exp,
   input  twg_side_t                in_side,
   input  logic signed [TW_W+GB:0]  in_x,
   input  logic signed [TW_W+GB:0]  in_y,
   output logic                     out_vld,
   output logic [LOGN-1:0]          out_exp,
   output logic signed [TW_W-1:0]   out_re,
   output logic signed [TW_W-1:0]   out_im
);

   localparam int XW   = TW_W + GB + 1;
   localparam int MAXV = (1 << (TW_W - 1)) - 1;
   localparam logic signed [TW_W-1:0] MAXS = TW_W'(MAXV);
   localparam logic signed [XW:0]     QMAX = (XW+1)'(MAXV);
   localparam logic signed [XW:0]     HALF = (XW+1)'(1 << (GB - 1));

   function automatic logic signed [TW_W-1:0] rnd_sat(input logic signed [XW-1:0] v);
      logic signed [XW:0] t;
      t = v;
      t = (t + HALF) >>> GB;
      if (t > QMAX)  return MAXS;
      if (t < -QMAX) return -MAXS;
      return t[TW_W-1:0];
   endfunction

   logic signed [TW_W-1:0] c, s, re_c, im_c;

   always_comb begin
      c = rnd_sat(in_x);
      s = rnd_sat(in_y);
      if (in_side.zero) begin
         c = MAXS;
         s = '0;
      end
      case (in_side.oct)
         3'd0:    begin re_c =  c; im_c = -s; end
         3'd1:    begin re_c =  s; im_c = -c; end
         3'd2:    begin re_c = -s; im_c = -c; end
         3'd3:    begin re_c = -c; im_c = -s; end
         3'd4:    begin re_c = -c; im_c =  s; end
         3'd5:    begin re_c = -s; im_c =  c; end
         3'd6:    begin re_c =  s; im_c =  c; end
         default: begin re_c =  c; im_c =  s; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= in_vld;
   end

   always_ff @(posedge clk) begin
      out_exp <= in_exp;
      out_re  <= re_c;
      out_im  <= im_c;
   end

endmodule

// File: rtl/twiddle_gen.sv
module twiddle_gen
   import twg_pkg::*;
#(
   parameter int LOGN         = 16,
   parameter int TW_W         = 19,
   parameter int NLANES       = 4,
   parameter int GB           = 6,
   parameter int CORDIC_ITERS = TW_W + 2,
   parameter int PW           = TW_W + 6,
   parameter int SW           = $clog2(LOGN) + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [SW-1:0]                stage,
   input  logic                         adv,
   output logic                         tw_vld,
   output logic [LOGN-1:0]              tw_exp,
   output logic [NLANES/2*TW_W-1:0]     tw_re,
   output logic [NLANES/2*TW_W-1:0]     tw_im
);

   localparam int NGRP = NLANES / 2;
   localparam int XW   = TW_W + GB + 1;

   if (LOGN < 3 || LOGN > 24) begin : g_bad_logn
      $error("twiddle_gen: LOGN must lie in 3..24");
   end
   if (TW_W < 8 || TW_W + GB > 30) begin : g_bad_width
      $error("twiddle_gen: TW_W must be at least 8 with TW_W+GB at most 30");
   end
   if (GB < 2 || GB > 8) begin : g_bad_guard
      $error("twiddle_gen: GB must lie in 2..8");
   end
   if (PW < LOGN || PW > 31) begin : g_bad_phase
      $error("twiddle_gen: PW must lie in LOGN..31");
   end
   if (NLANES < 2 || (NLANES % 2) != 0) begin : g_bad_lanes
      $error("twiddle_gen: NLANES must be even and at least 2");
   end
   if (CORDIC_ITERS < 4 || CORDIC_ITERS > 30) begin : g_bad_iters
      $error("twiddle_gen: CORDIC_ITERS must lie in 4..30");
   end

   logic                 rq_vld;
   logic [LOGN-1:0]      rq_exp;
   logic                 f_vld;
   logic [LOGN-1:0]      f_exp;
   twg_side_t            f_side;
   logic signed [PW-1:0] f_z;
   logic                 c_vld;
   logic [LOGN-1:0]      c_exp;
   twg_side_t            c_side;
   logic signed [XW-1:0] c_x, c_y;
   logic signed [TW_W-1:0] re_q, im_q;

   twg_seq #(.LOGN(LOGN), .SW(SW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .adv(adv), .stage(stage),
      .req_vld(rq_vld), .req_exp(rq_exp)
   );

   twg_fold #(.LOGN(LOGN), .PW(PW)) u_fold (
      .clk(clk), .rst_n(rst_n), .in_vld(rq_vld), .in_exp(rq_exp),
      .out_vld(f_vld), .out_exp(f_exp), .out_side(f_side), .out_z(f_z)
   );

   twg_cordic #(.LOGN(LOGN), .TW_W(TW_W), .GB(GB), .PW(PW), .ITERS(CORDIC_ITERS)) u_cordic (
      .clk(clk), .rst_n(rst_n), .in_vld(f_vld), .in_exp(f_exp), .in_side(f_side),
      .in_z(f_z), .out_vld(c_vld), .out_exp(c_exp), .out_side(c_side),
      .out_x(c_x), .out_y(c_y)
   );

   twg_unfold #(.LOGN(LOGN), .TW_W(TW_W), .GB(GB)) u_unfold (
      .clk(clk), .rst_n(rst_n), .in_vld(c_vld), .in_exp(c_exp), .in_side(c_side),
      .in_x(c_x), .in_y(c_y), .out_vld(tw_vld), .out_exp(tw_exp),
      .out_re(re_q), .out_im(im_q)
   );

   // one computed factor fans out to every butterfly group
   for (genvar g = 0; g < NGRP; g++) begin : g_bcast
      assign tw_re[g*TW_W +: TW_W] = re_q;
      assign tw_im[g*TW_W +: TW_W] = im_q;
   end

endmodule

// File: rtl/twg_chk.sv
module twg_chk #(
   parameter int LOGN = 16,
   parameter int TW_W = 19,
   parameter int NGRP = 2,
   parameter int LAT  = 22
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   adv,
   input logic                   tw_vld,
   input logic [LOGN-1:0]        tw_exp,
   input logic [NGRP*TW_W-1:0]   tw_re,
   input logic [NGRP*TW_W-1:0]   tw_im
);

   localparam int MAXV = (1 << (TW_W - 1)) - 1;
   localparam logic [TW_W-1:0] MAXP = TW_W'(MAXV);
   localparam logic [TW_W-1:0] MAXN = TW_W'(-MAXV);
   localparam logic [TW_W-1:0] MINV = {1'b1, {(TW_W-1){1'b0}}};
   localparam logic [LOGN-1:0] QTR  = LOGN'(1) << (LOGN - 2);

   logic [LAT:0] hist;
   logic         grp_diff;
   logic [TW_W-1:0] re0, im0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[LAT-1:0], adv};
   end

   always_comb begin
      re0 = tw_re[TW_W-1:0];
      im0 = tw_im[TW_W-1:0];
      grp_diff = 1'b0;
      for (int g = 1; g < NGRP; g++) begin
         if (tw_re[g*TW_W +: TW_W] != re0 || tw_im[g*TW_W +: TW_W] != im0) grp_diff = 1'b1;
      end
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      tw_vld == hist[LAT]);                                               // R6
   AST_GROUPS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      tw_vld |-> !grp_diff);                                              // R7
   AST_NO_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      tw_vld |-> (re0 != MINV && im0 != MINV));                           // R1
   AST_EXP0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_vld && tw_exp == '0) |-> (re0 == MAXP && im0 == '0));           // R2
   AST_QTR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_vld && tw_exp == QTR) |-> (re0 == '0 && im0 == MAXN));          // R3

endmodule

bind twiddle_gen twg_chk #(
   .LOGN(LOGN), .TW_W(TW_W), .NGRP(NLANES/2), .LAT(CORDIC_ITERS + 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .adv(adv), .tw_vld(tw_vld),
   .tw_exp(tw_exp), .tw_re(tw_re), .tw_im(tw_im)
);

// File: tb/sim_twiddle_gen.sv
`timescale 1ns/1ps
module sim_twiddle_gen;

   localparam int  LOGN   = 16;
   localparam int  TW_W   = 19;
   localparam int  NLANES = 4;
   localparam int  NGRP   = NLANES / 2;
   localparam int  ITERS  = TW_W + 2;
   localparam int  SW     = $clog2(LOGN) + 1;
   localparam int  N      = 1 << LOGN;
   localparam int  MAXV   = (1 << (TW_W - 1)) - 1;
   localparam int  LAT    = ITERS + 1;
   localparam int  QSZ    = 16384;
   localparam real PI     = 3.14159265358979323846;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     start = 1'b0;
   logic                     adv = 1'b0;
   logic [SW-1:0]            stage = '0;
   logic                     tw_vld;
   logic [LOGN-1:0]          tw_exp;
   logic [NGRP*TW_W-1:0]     tw_re;
   logic [NGRP*TW_W-1:0]     tw_im;

   always #2.5 clk = ~clk;

   twiddle_gen #(.LOGN(LOGN), .TW_W(TW_W), .NLANES(NLANES)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .stage(stage), .adv(adv),
      .tw_vld(tw_vld), .tw_exp(tw_exp), .tw_re(tw_re), .tw_im(tw_im)
   );

   int     n_chk = 0;
   int     n_fail = 0;
   longint cyc = 0;
   bit     done = 1'b0;
   int     qe [0:QSZ-1];
   longint qc [0:QSZ-1];
   int     wp = 0;
   int     rp = 0;
   int     n_out = 0;
   int     b_stage = 0;
   int     b_exp = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int b_step(input int s);
      return (s >= LOGN - 1) ? 1 : (N >> (s + 1));
   endfunction

   function automatic int rnd(input real x);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic int sgn(input logic [TW_W-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic push(input int k);
      qe[wp % QSZ] = k;
      qc[wp % QSZ] = cyc + 1;
      wp++;
   endtask

   // one driven cycle; the bench model of the exponent follows R4, R5, R8, R10
   task automatic cycle(input bit st, input bit ad, input int s);
      @(negedge clk);
      start = st;
      adv   = ad;
      stage = SW'(s);
      if (st) begin
         b_stage = s;
         if (ad) begin
            push(0);
            b_exp = b_step(s) % N;
         end else begin
            b_exp = 0;
         end
      end else if (ad) begin
         push(b_exp);
         b_exp = (b_exp + b_step(b_stage)) % N;
      end
   endtask

   task automatic drain();
      repeat (LAT + 3) cycle(1'b0, 1'b0, 0);
      check(rp == wp, "R6", "requests left without output", wp - rp, 0);
   endtask

   // output monitor: order, latency, value, exact points, group copies
   always @(negedge clk) begin : mon
      int k;
      longint rc;
      int re0, im0, er, ei, d;
      if (rst_n && !done && tw_vld) begin
         n_out++;
         if (rp == wp) begin
            check(1'b0, "R6", "output with no pending request", 1, 0);
         end else begin
            k  = qe[rp % QSZ];
            rc = qc[rp % QSZ];
            rp++;
            check(int'(tw_exp) == k, "R5", "exponent", tw_exp, k);
            check(cyc - rc == LAT, "R6", "latency", cyc - rc, LAT);
            re0 = sgn(tw_re[TW_W-1:0]);
            im0 = sgn(tw_im[TW_W-1:0]);
            if (k == 0) begin
               check(re0 == MAXV, "R2", "real at k=0", re0, MAXV);
               check(im0 == 0, "R2", "imag at k=0", im0, 0);
            end else if (k == N / 4) begin
               check(re0 == 0, "R3", "real at k=N/4", re0, 0);
               check(im0 == -MAXV, "R3", "imag at k=N/4", im0, -MAXV);
            end else begin
               er = rnd(real'(MAXV) * $cos(2.0 * PI * real'(k) / real'(N)));
               ei = rnd(-real'(MAXV) * $sin(2.0 * PI * real'(k) / real'(N)));
               d  = (re0 > er) ? re0 - er : er - re0;
               check(d <= 2, "R1", $sformatf("real at k=%0d", k), re0, er);
               d  = (im0 > ei) ? im0 - ei : ei - im0;
               check(d <= 2, "R1", $sformatf("imag at k=%0d", k), im0, ei);
            end
            for (int g = 1; g < NGRP; g++) begin
               check(tw_re[g*TW_W +: TW_W] == tw_re[TW_W-1:0] &&
                     tw_im[g*TW_W +: TW_W] == tw_im[TW_W-1:0],
                     "R7", $sformatf("group %0d real copy", g),
                     sgn(tw_re[g*TW_W +: TW_W]), re0);
            end
         end
      end
   end

   task automatic t_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(tw_vld == 1'b0, "R9", "valid after reset", tw_vld, 0);
      end
      // no start: stage 0 steps by N/2 from exponent 0
      repeat (3) cycle(1'b0, 1'b1, 0);
      drain();
      check(qe[0] == 0 && qe[1] == N / 2, "R9", "reset exponent sequence", qe[1], N / 2);
   endtask

   task automatic t_fine_sweep();
      // stage 12 steps by 8 and covers all octants, including folded pi/4
      cycle(1'b1, 1'b0, 12);
      repeat (N / 8) cycle(1'b0, 1'b1, 0);
      drain();
      // stage 15 steps by 1 near the origin
      cycle(1'b1, 1'b0, LOGN - 1);
      repeat (300) cycle(1'b0, 1'b1, 0);
      drain();
   endtask

   task automatic t_wrap();
      // stage 6 steps by 512 and wraps past N twice (R10)
      cycle(1'b1, 1'b0, 6);
      repeat (300) cycle(1'b0, 1'b1, 0);
      drain();
      check(b_exp == (300 * 512) % N, "R10", "model exponent after wrap", b_exp, (300 * 512) % N);
   endtask

   task automatic t_start_adv();
      int w0;
      w0 = wp;
      cycle(1'b1, 1'b1, 2);
      repeat (5) cycle(1'b0, 1'b1, 0);
      cycle(1'b1, 1'b1, 1);
      repeat (3) cycle(1'b0, 1'b1, 0);
      drain();
      check(qe[w0 % QSZ] == 0 && qe[(w0 + 6) % QSZ] == 0, "R4",
            "restart with request in same cycle", qe[(w0 + 6) % QSZ], 0);
   endtask

   task automatic t_gaps();
      int o0, r0;
      o0 = n_out;
      r0 = wp;
      cycle(1'b1, 1'b0, 3);
      for (int i = 0; i < 40; i++) begin
         cycle(1'b0, (i % 3) != 1, 0);
      end
      drain();
      // R8: gaps emit nothing and the sequence resumes where it paused
      check(n_out - o0 == wp - r0, "R8", "outputs versus requests across gaps", n_out - o0, wp - r0);
   endtask

   task automatic t_clamp();
      int w0;
      w0 = wp;
      cycle(1'b1, 1'b0, 31);
      repeat (4) cycle(1'b0, 1'b1, 0);
      drain();
      check(qe[(w0 + 3) % QSZ] == 3, "R5", "step 1 for stage beyond LOGN-1", qe[(w0 + 3) % QSZ], 3);
   endtask

   initial begin
      t_reset();
      t_fine_sweep();
      t_wrap();
      t_start_adv();
      t_gaps();
      t_clamp();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule